// File: doc/BRIEF.md
# SD Card SPI Command Engine

This block issues a single SD-card command in SPI mode and gathers the card's answer. A controller supplies a 6-bit command index, a 32-bit argument and a hold flag, then pulses `start`. The engine pulls chip select low and sends the six-byte command frame. It then clocks filler bytes until the card answers. It returns the one-byte status, a 32-bit trailer word when the command carries one, and a timeout flag. Every byte goes through an external byte-wide SPI shifter over a request/acknowledge handshake. The engine only sequences bytes and never touches the serial clock.

Once the answer is taken, the engine normally raises chip select and sends one more filler byte so the card can release its output. In hold mode chip select stays low after the answer, so a data-block phase run by other logic can follow directly. The status byte is reported unchanged: bit 0 is idle, bit 1 erase reset, bit 2 illegal command, bit 3 CRC error, bit 4 erase sequence error, bit 5 address error and bit 6 parameter error. The engine itself only tests bit 7.

Top module: `sd_cmd_engine`

## Requirements
- R1: The first frame byte is 0x40 OR the latched command index. The next four bytes are the argument, most significant byte first. Index and argument are latched at `start`, so later changes to those inputs have no effect on the frame.
- R2: The sixth frame byte is 0x87 when the index is 8 and 0x95 for every other index.
- R3: After the frame the engine sends 0xFF bytes. The first received byte with bit 7 clear is returned on `r1`. Bytes received while the frame is being sent are ignored, whatever their value.
- R4: If POLL_LIMIT (default 5000) poll bytes pass without a byte with bit 7 clear, `timeout` is set and `r1` reads 0xFF. A valid byte on exactly the POLL_LIMIT-th poll is accepted, with no timeout.
- R5: For index 8 and index 58, the four bytes after the status are captured into `trail`, first byte in bits 31:24. For any other index, and on a timeout, `trail` reads zero.
- R6: In normal mode, chip select goes high after the response, one 0xFF byte is exchanged with chip select high, and `done` then pulses.
- R7: In hold mode, chip select stays low after the response (and after the trailer when there is one). No extra byte is sent, and `done` pulses after the last response byte. On a timeout, chip select is released and the extra 0xFF byte is sent even in hold mode.
- R8: `spi_req` stays high with `spi_tx` stable until `spi_ack` is seen. It is low for at least one cycle after each acknowledge, so only one byte exchange is ever outstanding.
- R9: `start` is taken only while `busy` is low, and is ignored during a command. `done` is a one-cycle pulse with `busy` low. A `start` in the `done` cycle begins the next command.
- R10: While reset is held, `cs_n` is high and `busy`, `done` and `spi_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a command (taken only when idle) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| hold_cs | input | 1 | Keep chip select low after a good response |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| r1 | output | 8 | Status byte (0xFF after a timeout) |
| trail | output | 32 | Trailer word for index 8 and 58, else zero |
| timeout | output | 1 | No response within POLL_LIMIT poll bytes |
| cs_n | output | 1 | Card chip select, active low |
| spi_req | output | 1 | Byte exchange request to the shifter |
| spi_tx | output | 8 | Byte to transmit |
| spi_ack | input | 1 | Exchange complete, `spi_rx` valid |
| spi_rx | input | 8 | Byte received in the exchange |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the final allowed poll byte and the timeout decision. The bench answers on exactly the POLL_LIMIT-th poll byte and expects a good status with no timeout. It then withholds any answer and expects a timeout whose released chip select and trailing filler byte override hold mode. The second pair is a `done` pulse and a new `start`. The bench raises `start` in the same cycle that a hold-mode command reports completion. It judges the result on the exchanged byte stream: the new frame must follow with chip select still low and no filler byte in between.

// File: rtl/sd_cmd_pkg.sv
// Package: shared constants, state type and helper for the SD command engine.
// Assumes the SPI-mode command frame of start bits, index, 32-bit argument and CRC.
package sd_cmd_pkg;

    localparam int          ARG_BYTES   = 4;
    localparam logic [7:0]  FILL_BYTE   = 8'hFF;
    localparam logic [7:0]  CRC_GENERIC = 8'h95;
    localparam logic [7:0]  CRC_IFCOND  = 8'h87;
    localparam logic [5:0]  IDX_IFCOND  = 6'd8;
    localparam logic [5:0]  IDX_OCR     = 6'd58;
    localparam logic [1:0]  START_BITS  = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FRAME,
        ST_POLL,
        ST_TRAIL,
        ST_TAIL
    } eng_state_t;

    // True for commands whose response carries a trailing word.
    function automatic logic has_trailer(input logic [5:0] idx);
        return (idx == IDX_IFCOND) || (idx == IDX_OCR);
    endfunction

endpackage

// File: rtl/sd_frame_mux.sv
// Selects one byte of the command frame by position.
// Assumes sel counts 0..ARG_BYTES+1; positions beyond the argument give the CRC.
module sd_frame_mux
    import sd_cmd_pkg::*;
#(
    parameter int NBYTES = ARG_BYTES,
    localparam int SELW  = $clog2(NBYTES + 2)
) (
    input  logic [5:0]          idx,
    input  logic [8*NBYTES-1:0] arg,
    input  logic [SELW-1:0]     sel,
    output logic [7:0]          frame_byte
);

    logic [7:0] arg_b [NBYTES];
    logic [7:0] crc_b;

    // Split the argument into bytes, most significant first.
    for (genvar g = 0; g < NBYTES; g++) begin : g_split
        assign arg_b[g] = arg[8*(NBYTES-1-g) +: 8];
    end

    // Fixed check byte: one value for the interface-condition command.
    assign crc_b = (idx == IDX_IFCOND) ? CRC_IFCOND : CRC_GENERIC;

    // Byte selection by frame position.
    always_comb begin
        frame_byte = crc_b;
        for (int i = 0; i < NBYTES; i++) begin
            if (sel == SELW'(i + 1)) frame_byte = arg_b[i];
        end
        if (sel == '0) frame_byte = {START_BITS, idx};
    end

endmodule

// File: rtl/sd_poll_timer.sv
// Counts poll bytes that carried no response and flags the final allowed one.
// Assumes step is pulsed once per completed non-matching poll exchange.
module sd_poll_timer #(
    parameter int LIMIT = 5000,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic at_last
);

    logic [CW-1:0] cnt;

    // Poll counter, cleared at each command start.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (step)       cnt <= cnt + 1'b1;
    end

    // The poll now in flight is the LIMIT-th one.
    assign at_last = (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/sd_trail_capture.sv
// Shifts in trailing response bytes, first byte ending up most significant.
// Assumes shift is pulsed once per completed trailer exchange.
module sd_trail_capture #(
    parameter int BYTES = 4,
    localparam int CW   = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               shift,
    input  logic [7:0]         din,
    output logic [8*BYTES-1:0] word,
    output logic               last
);

    logic [CW-1:0] cnt;

    // Word shift register and byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word <= '0;
            cnt  <= '0;
        end else if (shift) begin
            word <= {word[8*BYTES-9:0], din};
            cnt  <= cnt + 1'b1;
        end
    end

    // Current exchange delivers the final trailer byte.
    assign last = (cnt == CW'(BYTES - 1));

endmodule

// File: rtl/sd_cmd_engine.sv
// Issues one SD SPI-mode command through a byte shifter and gathers the reply.
// Assumes the shifter holds spi_ack for one cycle per exchange with spi_rx valid.
module sd_cmd_engine
    import sd_cmd_pkg::*;
#(
    parameter int POLL_LIMIT  = 5000,
    parameter int TRAIL_BYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [5:0]               cmd_idx,
    input  logic [8*ARG_BYTES-1:0]   cmd_arg,
    input  logic                     hold_cs,
    output logic                     busy,
    output logic                     done,
    output logic [7:0]               r1,
    output logic [8*TRAIL_BYTES-1:0] trail,
    output logic                     timeout,
    output logic                     cs_n,
    output logic                     spi_req,
    output logic [7:0]               spi_tx,
    input  logic                     spi_ack,
    input  logic [7:0]               spi_rx
);

    localparam int FRAME_LEN = ARG_BYTES + 2;
    localparam int FW        = $clog2(FRAME_LEN);

    eng_state_t             state;
    logic [FW-1:0]          fidx;
    logic                   gap_q;
    logic                   cs_q;
    logic                   done_q;
    logic                   to_q;
    logic [7:0]             r1_q;
    logic [5:0]             idx_q;
    logic [8*ARG_BYTES-1:0] arg_q;
    logic                   hold_q;
    logic [7:0]             frame_byte;
    logic                   xfer;
    logic                   accept;
    logic                   poll_last;
    logic                   trail_last;
    logic                   rx_valid;

    assign accept   = (state == ST_IDLE) && start;
    assign xfer     = spi_req && spi_ack;
    assign rx_valid = !spi_rx[7];

    sd_frame_mux #(.NBYTES(ARG_BYTES)) u_frame (
        .idx        (idx_q),
        .arg        (arg_q),
        .sel        (fidx),
        .frame_byte (frame_byte)
    );

    sd_poll_timer #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .step    ((state == ST_POLL) && xfer && !rx_valid),
        .at_last (poll_last)
    );

    sd_trail_capture #(.BYTES(TRAIL_BYTES)) u_trail (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .shift ((state == ST_TRAIL) && xfer),
        .din   (spi_rx),
        .word  (trail),
        .last  (trail_last)
    );

    // Main sequencer: frame, poll, trailer, release byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            fidx   <= '0;
            gap_q  <= 1'b0;
            cs_q   <= 1'b1;
            done_q <= 1'b0;
            to_q   <= 1'b0;
            r1_q   <= FILL_BYTE;
            idx_q  <= '0;
            arg_q  <= '0;
            hold_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            gap_q  <= xfer;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        idx_q  <= cmd_idx;
                        arg_q  <= cmd_arg;
                        hold_q <= hold_cs;
                        cs_q   <= 1'b0;
                        fidx   <= '0;
                        r1_q   <= FILL_BYTE;
                        to_q   <= 1'b0;
                        state  <= ST_FRAME;
                    end
                end
                ST_FRAME: begin
                    if (xfer) begin
                        if (fidx == FW'(FRAME_LEN - 1)) state <= ST_POLL;
                        else                             fidx  <= fidx + 1'b1;
                    end
                end
                ST_POLL: begin
                    if (xfer) begin
                        if (rx_valid) begin
                            r1_q <= spi_rx;
                            if (has_trailer(idx_q)) begin
                                state <= ST_TRAIL;
                            end else if (hold_q) begin
                                done_q <= 1'b1;
                                state  <= ST_IDLE;
                            end else begin
                                cs_q  <= 1'b1;
                                state <= ST_TAIL;
                            end
                        end else if (poll_last) begin
                            to_q  <= 1'b1;
                            cs_q  <= 1'b1;
                            state <= ST_TAIL;
                        end
                    end
                end
                ST_TRAIL: begin
                    if (xfer && trail_last) begin
                        if (hold_q) begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            cs_q  <= 1'b1;
                            state <= ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    if (xfer) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output drive: request only in transfer states outside the gap cycle.
    assign busy    = (state != ST_IDLE);
    assign spi_req = busy && !gap_q;
    assign spi_tx  = (state == ST_FRAME) ? frame_byte : FILL_BYTE;
    assign cs_n    = cs_q;
    assign done    = done_q;
    assign r1      = r1_q;
    assign timeout = to_q;

endmodule

// File: rtl/sd_cmd_engine_chk.sv
// Property checker for sd_cmd_engine, bound to every instance of it.
// Assumes it observes only the top-level ports.
module sd_cmd_engine_chk #(
    parameter int TW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [5:0]    cmd_idx,
    input logic          busy,
    input logic          done,
    input logic [7:0]    r1,
    input logic [TW-1:0] trail,
    input logic          timeout,
    input logic          cs_n,
    input logic          spi_req,
    input logic [7:0]    spi_tx,
    input logic          spi_ack
);

    p_reset_state_r10: assert property (@(posedge clk)
        !rst_n |=> (cs_n && !busy && !spi_req && !done));

    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx)));

    p_req_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && spi_ack) |=> !spi_req);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !spi_req);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_first_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (spi_req && spi_tx == {2'b01, $past(cmd_idx)}));

    p_status_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !timeout) |-> !r1[7]);

    p_timeout_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (r1 == 8'hFF));

    p_timeout_trail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (trail == '0));

    p_timeout_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> cs_n);

endmodule

bind sd_cmd_engine sd_cmd_engine_chk #(.TW(8*TRAIL_BYTES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_idx (cmd_idx),
    .busy    (busy),
    .done    (done),
    .r1      (r1),
    .trail   (trail),
    .timeout (timeout),
    .cs_n    (cs_n),
    .spi_req (spi_req),
    .spi_tx  (spi_tx),
    .spi_ack (spi_ack)
);

// File: tb/sd_cmd_engine_bench.sv
// Bench: behavioural shifter/card model plus expected byte stream per command.
module sd_cmd_engine_bench;

    localparam int LIMIT = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  cmd_idx = '0;
    logic [31:0] cmd_arg = '0;
    logic        hold_cs = 1'b0;
    logic        busy, done, timeout, cs_n, spi_req;
    logic [7:0]  r1, spi_tx;
    logic [31:0] trail;
    logic        spi_ack = 1'b0;
    logic [7:0]  spi_rx = 8'h00;

    int checks = 0;
    int failures = 0;

    // Model state for the command in flight.
    logic [8:0]  exp_q[$];
    int          pos = 0;
    int          dly_cnt = 0;
    int          m_poll_at = 0;
    logic [7:0]  m_r1 = 8'h00;
    logic [31:0] m_trail = '0;
    logic [7:0]  e_r1;
    logic [31:0] e_trail;
    logic        e_to;
    logic        e_cs;

    always #10 clk = ~clk;

    sd_cmd_engine u_sd_cmd_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx),
        .cmd_arg(cmd_arg), .hold_cs(hold_cs), .busy(busy), .done(done),
        .r1(r1), .trail(trail), .timeout(timeout), .cs_n(cs_n),
        .spi_req(spi_req), .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx)
    );

    function automatic logic [7:0] card_byte(input int p);
        int k;
        if (p < 6) return 8'h3C;              // frame phase: bit 7 clear, must be ignored
        k = p - 5;
        if (m_poll_at == 0 || k < m_poll_at) return (k % 2 == 0) ? 8'hFF : 8'hA5;
        if (k == m_poll_at) return m_r1;
        if (k <= m_poll_at + 4) return m_trail[8*(4-(k-m_poll_at)) +: 8];
        return 8'hFF;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Shifter and card model: acknowledges after a varying delay, checks each byte.
    initial begin
        forever begin
            @(negedge clk);
            if (spi_ack) begin
                spi_ack = 1'b0;
            end else if (rst_n && spi_req) begin
                if (dly_cnt >= pos % 3) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R6 R7", "unexpected byte", {55'd0, cs_n, spi_tx}, 64'h0);
                    end else begin
                        logic [8:0] e;
                        e = exp_q.pop_front();
                        check({cs_n, spi_tx} == e, "R1 R2 R3 R6 R7 R9",
                              "byte stream", {55'd0, cs_n, spi_tx}, {55'd0, e});
                    end
                    spi_rx  = card_byte(pos);
                    spi_ack = 1'b1;
                    pos++;
                    dly_cnt = 0;
                end else begin
                    dly_cnt++;
                end
            end
        end
    end

    // Every-cycle rule: no request while idle.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !busy)
                check(!spi_req, "R8 R9", "request while idle", {63'd0, spi_req}, 64'd0);
        end
    end

    // Load the model and pulse start at the current negedge.
    task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input bit hold,
                         input int poll_at, input logic [7:0] rv, input logic [31:0] tv);
        bit found, trl;
        int np;
        found = (poll_at != 0) && (poll_at <= LIMIT);
        trl = (idx == 6'd8) || (idx == 6'd58);
        m_poll_at = poll_at; m_r1 = rv; m_trail = tv;
        pos = 0; dly_cnt = 0;
        exp_q.delete();
        exp_q.push_back({1'b0, 2'b01, idx});
        for (int i = 3; i >= 0; i--) exp_q.push_back({1'b0, arg[8*i +: 8]});
        exp_q.push_back({1'b0, (idx == 6'd8) ? 8'h87 : 8'h95});
        np = found ? poll_at : LIMIT;
        for (int i = 0; i < np; i++) exp_q.push_back(9'h0FF);
        if (found && trl) for (int i = 0; i < 4; i++) exp_q.push_back(9'h0FF);
        if (!(found && hold)) exp_q.push_back(9'h1FF);
        e_r1 = found ? rv : 8'hFF;
        e_trail = (found && trl) ? tv : 32'h0;
        e_to = !found;
        e_cs = !(found && hold);
        cmd_idx = idx; cmd_arg = arg; hold_cs = hold; start = 1'b1;
        @(negedge clk);
        start = 1'b0; cmd_idx = ~idx; cmd_arg = ~arg; hold_cs = ~hold;
    endtask

    // Wait for done; optionally poke start mid-command. Leaves us at the done negedge.
    task automatic finish(input string tag, input bit poke);
        int n = 0;
        while (!done) begin
            @(negedge clk);
            n++;
            if (poke && n == 8)  begin start = 1'b1; cmd_idx = 6'h11; cmd_arg = 32'hDEAD0000; end
            if (poke && n == 9)  start = 1'b0;
        end
        check(r1 == e_r1, "R3 R4", {tag, " r1"}, {56'd0, r1}, {56'd0, e_r1});
        check(trail == e_trail, "R5", {tag, " trail"}, {32'd0, trail}, {32'd0, e_trail});
        check(timeout == e_to, "R4", {tag, " timeout"}, {63'd0, timeout}, {63'd0, e_to});
        check(cs_n == e_cs, "R6 R7", {tag, " cs_n after done"}, {63'd0, cs_n}, {63'd0, e_cs});
        check(!busy, "R9", {tag, " busy at done"}, {63'd0, busy}, 64'd0);
        check(exp_q.size() == 0, "R6 R7", {tag, " bytes left"}, exp_q.size(), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n && !busy && !spi_req && !done, "R10", "reset state",
              {60'd0, cs_n, busy, spi_req, done}, 64'h8);
        rst_n = 1'b1;
        @(negedge clk);

        issue(6'd0, 32'h0, 1'b0, 2, 8'h01, 32'h0);           // R1 R2 R3 R6
        finish("go-idle", 1'b0);
        @(negedge clk);
        issue(6'd8, 32'h000001AA, 1'b0, 1, 8'h01, 32'h000001AA); // R2 0x87, R5
        finish("if-cond", 1'b0);
        @(negedge clk);
        issue(6'd58, 32'h0, 1'b1, 3, 8'h00, 32'hC0FF8000);   // R5 with R7 hold
        finish("ocr-hold", 1'b0);
        @(negedge clk);
        issue(6'd17, 32'h12345678, 1'b0, 4, 8'h00, 32'h0);   // R9 start ignored while busy
        finish("read-poke", 1'b1);
        @(negedge clk);
        issue(6'd9, 32'h0, 1'b1, 1, 8'h00, 32'h0);           // R7 hold
        finish("csd-hold", 1'b0);
        issue(6'd16, 32'h00000200, 1'b0, 2, 8'h04, 32'h0);   // R9 start in done cycle
        finish("blklen-chained", 1'b0);
        @(negedge clk);
        issue(6'd41, 32'h40000000, 1'b0, LIMIT, 8'h00, 32'h0); // R4 last poll accepted
        finish("last-poll", 1'b0);
        @(negedge clk);
        issue(6'd55, 32'h0, 1'b1, 0, 8'h00, 32'h0);          // R4 R7 timeout in hold
        finish("timeout-hold", 1'b0);
        @(negedge clk);
        issue(6'd8, 32'h000001AA, 1'b0, 0, 8'h00, 32'h0);    // R5 no trailer on timeout
        finish("timeout-ifcond", 1'b0);
        repeat (4) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(190000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule